// File: doc/BRIEF.md
# Mode and Status Control Register

This block is one 8-bit register on a small parallel processor bus. A write to it sets a continuous status-refresh enable and can fire three self-clearing actions: a one-shot refresh of the status flags, a synchronous reset of the functions around it, and a single counting step of an external 32-bit counter. A read returns five latched status flags from neighbouring blocks, together with the current state of the mode bits. Several bit positions carry one meaning on a write and another on a read.

The status flags are captured into latches that have no reset. They change only on a refresh pulse, or on every clock while continuous refresh is on. They hold their value through both reset kinds. Because no reset touches them, a four-state simulator shows them as unknown after power-up until the first refresh. The counters, shifters and address decode are outside this block. They appear here as plain input flags and one-cycle output strobes. The bus is a plain strobed register interface with no valid/ready flow: a write is taken on the clock edge where chip select, write and a matching address are all high, and read data is combinational.

Top module: `modestat_ctrl`

## Requirements
- R1: Asynchronous reset (rst_n low) loads the write-side image 8'hB8. Continuous refresh is then on and all three action bits are 0, so the low three read bits are 3'b100.
- R2: Read layout: bit 7 output-buffer room, bit 6 input-buffer data available, bit 5 counter idle or at terminal count, bit 4 select-0 buffer room, bit 3 select-1 buffer room. Bit 2 is the continuous-refresh enable. Bit 1 is the pending sync reset. Bit 0 is the pending step.
- R3: Write bit 3 sets continuous refresh. While it is on, each status latch takes its source on every clock edge, so a source change is visible on a read one edge later.
- R4: Writing 1 to bit 2 raises upd_strobe for exactly the next cycle, and the latches take their sources at the end of that cycle. A read of bit 2 always shows the continuous enable and never the written refresh bit.
- R5: The status latches are never reset. They hold their value while neither continuous refresh nor a refresh pulse is active, and also while rst_n is low.
- R6: Writing 1 to bit 1 raises func_rst for exactly one cycle, and bit 1 reads 1 during that cycle. On the following edge the mode bits reload 8'hB8. The status latches are left as they were.
- R7: Writing 1 to bit 0 raises step_strobe for exactly one cycle, and bit 0 reads 1 during that cycle.
- R8: The register reacts only to bus_cs high at address REG_ADDR (default 3'b111). Other writes change nothing. When the register is not selected for a read, bus_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Chip select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when not selected |
| flag_out_room | input | 1 | Output buffer can take a byte |
| flag_in_avail | input | 1 | Input buffer holds a byte |
| flag_cnt_idle | input | 1 | Counter unloaded or at terminal count |
| flag_sel0_room | input | 1 | Select-0 buffer can take a byte |
| flag_sel1_room | input | 1 | Select-1 buffer can take a byte |
| cont_en | output | 1 | Continuous refresh enable |
| upd_strobe | output | 1 | One-cycle status refresh pulse |
| func_rst | output | 1 | One-cycle synchronous reset of the other functions |
| step_strobe | output | 1 | One-cycle counter single step |

## Verification
The bench goes after the bits that change meaning between read and write. A design that echoed the written refresh bit on read bit 2, or put the continuous enable on bit 3, would return the wrong byte. It holds the sources still, then changes them, during async reset and after continuous refresh is turned off. A design that reset the latches, or let them follow their sources while disabled, would show new flags too early or cleared flags. It counts the exact width of each action pulse and checks the reload after a sync reset, which shows up a pulse that sticks, a latch that the sync reset clears, or a reset that fails to restore continuous refresh. It also writes to a wrong address and reads with chip select low, to catch a loose address decode.

// File: rtl/modestat_pkg.sv
package modestat_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned N_STAT   = 5;
  // write-side bit positions
  localparam int unsigned B_CONT   = 3;
  localparam int unsigned B_UPD    = 2;
  localparam int unsigned B_SRST   = 1;
  localparam int unsigned B_STEP   = 0;
  // read-side: status occupies the top N_STAT bits
  localparam int unsigned B_STAT_LO = DATA_W - N_STAT;
  localparam logic [DATA_W-1:0] RST_IMAGE = 8'hB8;

  typedef struct packed {
    logic cont;
    logic upd;
    logic srst;
    logic step;
  } mode_t;

  function automatic mode_t image_to_mode(input logic [DATA_W-1:0] img);
    mode_t m;
    m.cont = img[B_CONT];
    m.upd  = img[B_UPD];
    m.srst = img[B_SRST];
    m.step = img[B_STEP];
    return m;
  endfunction
endpackage

// File: rtl/modestat_mode_reg.sv
module modestat_mode_reg
  import modestat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  output mode_t             mode_q
);
  localparam mode_t RST_MODE = image_to_mode(RST_IMAGE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RST_MODE;
    end else if (mode_q.srst) begin
      // sync reset completes: whole mode image reloads, action bits clear
      mode_q <= RST_MODE;
    end else if (wr_hit) begin
      mode_q <= image_to_mode(wdata);
    end else begin
      mode_q.upd  <= 1'b0;
      mode_q.srst <= 1'b0;
      mode_q.step <= 1'b0;
    end
  end
endmodule

// File: rtl/modestat_status_latch.sv
module modestat_status_latch #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [N-1:0] src,
  output logic [N-1:0] q
);
  // No reset: the flags keep their value through every reset.
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (en && rst_n) q[i] <= src[i];
    end
  end
endmodule

// File: rtl/modestat_read_mux.sv
module modestat_read_mux
  import modestat_pkg::*;
(
  input  logic              rd_hit,
  input  logic [N_STAT-1:0] stat,
  input  mode_t             mode,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] image;

  always_comb begin
    image = '0;
    image[DATA_W-1:B_STAT_LO] = stat;
    // bit 2 on read shows the continuous enable; refresh bit is never visible
    image[B_UPD]  = mode.cont;
    image[B_SRST] = mode.srst;
    image[B_STEP] = mode.step;
    rdata = rd_hit ? image : '0;
  end
endmodule

// File: rtl/modestat_ctrl.sv
module modestat_ctrl
  import modestat_pkg::*;
#(
  parameter int unsigned     ADDR_W   = 3,
  parameter logic [ADDR_W-1:0] REG_ADDR = 3'b111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              flag_out_room,
  input  logic              flag_in_avail,
  input  logic              flag_cnt_idle,
  input  logic              flag_sel0_room,
  input  logic              flag_sel1_room,
  output logic              cont_en,
  output logic              upd_strobe,
  output logic              func_rst,
  output logic              step_strobe
);
  logic              sel, wr_hit, rd_hit, lat_en;
  logic [N_STAT-1:0] src_vec, stat_q;
  mode_t             mode_q;

  assign sel     = bus_cs && (bus_addr == REG_ADDR);
  assign wr_hit  = sel && bus_wr;
  assign rd_hit  = sel && !bus_wr;
  assign src_vec = {flag_out_room, flag_in_avail, flag_cnt_idle,
                    flag_sel0_room, flag_sel1_room};

  modestat_mode_reg u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_hit (wr_hit),
    .wdata  (bus_wdata),
    .mode_q (mode_q)
  );

  assign lat_en = mode_q.cont || mode_q.upd;

  modestat_status_latch #(.N(N_STAT)) u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (lat_en),
    .src   (src_vec),
    .q     (stat_q)
  );

  modestat_read_mux u_rd (
    .rd_hit (rd_hit),
    .stat   (stat_q),
    .mode   (mode_q),
    .rdata  (bus_rdata)
  );

  assign cont_en     = mode_q.cont;
  assign upd_strobe  = mode_q.upd;
  assign func_rst    = mode_q.srst;
  assign step_strobe = mode_q.step;
endmodule

// File: rtl/modestat_ctrl_chk.sv
module modestat_ctrl_chk #(
  parameter int unsigned       ADDR_W   = 3,
  parameter logic [ADDR_W-1:0] REG_ADDR = 3'b111
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_cs,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic [4:0]        src,
  input logic [4:0]        stat,
  input logic              cont_en,
  input logic              upd_strobe,
  input logic              func_rst,
  input logic              step_strobe
);
  logic hit;
  assign hit = bus_cs && bus_wr && (bus_addr == REG_ADDR);

  assert_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cont_en |=> (stat == $past(src)));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cont_en && !upd_strobe) |=> $stable(stat));
  assert_upd_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && bus_wdata[2] && !func_rst) |=> upd_strobe);
  assert_upd_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_strobe && !hit) |=> !upd_strobe);
  assert_srst_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    func_rst |=> (!func_rst && cont_en));
  assert_step_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_strobe && !hit) |=> !step_strobe);
  assert_no_stray_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> (!upd_strobe && !func_rst && !step_strobe));
endmodule

bind modestat_ctrl modestat_ctrl_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_cs      (bus_cs),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .src         (src_vec),
  .stat        (stat_q),
  .cont_en     (cont_en),
  .upd_strobe  (upd_strobe),
  .func_rst    (func_rst),
  .step_strobe (step_strobe)
);

// File: tb/tb_modestat_ctrl.sv
module tb_modestat_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_cs = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'b000;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [4:0] src = 5'b00000;
  logic       cont_en, upd_strobe, func_rst, step_strobe;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] exp;
    logic [7:0] mask;
    string      req;
  } item_t;
  item_t exp_q[$];
  event  sample_ev;

  always #2.5 clk = ~clk;

  modestat_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .flag_out_room(src[4]), .flag_in_avail(src[3]), .flag_cnt_idle(src[2]),
    .flag_sel0_room(src[1]), .flag_sel1_room(src[0]),
    .cont_en(cont_en), .upd_strobe(upd_strobe), .func_rst(func_rst),
    .step_strobe(step_strobe)
  );

  // monitor: pops expected reads and compares
  initial begin
    forever begin
      @(sample_ev);
      while (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        n_tests++;
        if ((bus_rdata & it.mask) !== (it.exp & it.mask)) begin
          n_fail++;
          $display("FAIL %s: rdata=%h expected=%h (mask %h)", it.req,
                   bus_rdata, it.exp, it.mask);
        end
      end
    end
  end

  task automatic chk_bit(input logic act, input logic exp, input string req);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // read in the current cycle (call at a falling edge)
  task automatic rd_check(input logic [7:0] exp, input logic [7:0] mask, input string req);
    item_t it;
    it.exp = exp; it.mask = mask; it.req = req;
    exp_q.push_back(it);
    bus_cs = 1'b1; bus_wr = 1'b0; bus_addr = 3'b111;
    #1;
    ->sample_ev;
    #0.5;
    bus_cs = 1'b0;
  endtask

  // write; returns at the falling edge after the write edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_cs = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_cs = 1'b0; bus_wr = 1'b0;
  endtask

  initial begin
    src = 5'b10110;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd_check(8'h04, 8'h07, "R1 reset image low bits");
    @(negedge clk);
    rd_check(8'hB4, 8'hFF, "R2 R3 layout after first continuous capture");
    src = 5'b01101;
    rd_check(8'hB4, 8'hF8, "R3 one-edge latency");
    @(negedge clk);
    rd_check(8'h6C, 8'hFF, "R3 follows source");

    wr(3'b111, 8'h00);
    rd_check(8'h68, 8'hFF, "R3 continuous off, bit2 reads 0");
    src = 5'b11001;
    repeat (2) @(negedge clk);
    rd_check(8'h68, 8'hFF, "R5 latches hold when disabled");

    wr(3'b111, 8'h04);
    chk_bit(upd_strobe, 1'b1, "R4 refresh pulse high");
    rd_check(8'h00, 8'h07, "R4 refresh bit not readable");
    @(negedge clk);
    chk_bit(upd_strobe, 1'b0, "R4 refresh pulse one cycle");
    rd_check(8'hC8, 8'hFF, "R4 refreshed status");

    src = 5'b00111;
    rst_n = 1'b0;
    rd_check(8'hC8, 8'hF8, "R5 latches kept at reset entry");
    repeat (2) @(negedge clk);
    rd_check(8'hC8, 8'hF8, "R5 latches kept during reset");
    rst_n = 1'b1;
    @(negedge clk);
    rd_check(8'h3C, 8'hFF, "R1 continuous on after reset");

    wr(3'b010, 8'h04);
    chk_bit(upd_strobe, 1'b0, "R8 wrong-address write no pulse");
    wr(3'b011, 8'h00);
    rd_check(8'h04, 8'h07, "R8 wrong-address write leaves mode");
    bus_cs = 1'b0; bus_wr = 1'b0; bus_addr = 3'b111;
    #1;
    chk_bit(bus_rdata == 8'h00, 1'b1, "R8 rdata zero when cs low");

    wr(3'b111, 8'h00);
    wr(3'b111, 8'h02);
    src = 5'b10000;
    chk_bit(func_rst, 1'b1, "R6 sync reset pulse high");
    rd_check(8'h02, 8'h07, "R6 bit1 reads 1 during reset");
    @(negedge clk);
    chk_bit(func_rst, 1'b0, "R6 sync reset one cycle");
    rd_check(8'h3C, 8'hFF, "R6 mode reloaded, latches untouched");
    @(negedge clk);
    rd_check(8'h84, 8'hFF, "R6 continuous refresh restored");

    wr(3'b111, 8'h09);
    chk_bit(step_strobe, 1'b1, "R7 step pulse high");
    rd_check(8'h05, 8'h07, "R7 bit0 reads 1 during step");
    @(negedge clk);
    chk_bit(step_strobe, 1'b0, "R7 step one cycle");
    rd_check(8'h04, 8'h07, "R7 bit0 cleared");

    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
      end
    join_any
    #1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule